// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects event pulses from up to 32 on-chip peripheral sources and drives a single interrupt request toward the processor core. Each source has a pending flag, an enable flag and an in-service flag. All sources share one fixed priority order, and a higher source index means a higher priority. The request is raised only for a pending, enabled source that ranks strictly above every source still marked in service. Software therefore decides how far nesting goes by choosing when it clears in-service flags.

The handler writes the acknowledge bit of a 16-bit vector register to find out which source to serve. On that write, the block captures the index of the winning source as a 5-bit vector number and marks that source in service. If the source is configured as single-event, the block also clears its pending flag. If nothing is eligible at the acknowledge, the block stores the error code 0 and changes no other state. All registers are reached through one write port and one read port, and the read port returns data one cycle after the address.

Top module: `nest_irq_ctrl`

## Requirements
- R1: An event pulse on a present source sets its pending flag at the next edge. Writing 1 to a pending bit (address 1) clears it. An event in the same cycle as that clear wins, and the flag stays set.
- R2: irq_o is high exactly when some pending, enabled source has an index strictly greater than the highest index whose in-service flag is set, or when any pending, enabled source exists while no in-service flag is set. Index 31 is the highest priority.
- R3: Writing 1 to an in-service bit (address 2) clears it. From the following cycle, requests are compared only against the in-service flags that remain set.
- R4: Bit positions of sources not marked present in SRC_PRESENT (by default source 0) always read 0 in the enable, pending, in-service and mode registers.
- R5: The vector register (address 3) reads as vector number in bits [15:11], zeros in bits [10:1] and the acknowledge bit in bit [0]. It resets to 0, and writes to bits [10:1] have no effect.
- R6: Writing 1 to bit 0 of address 3 while irq_o is high loads the vector number with the index of the highest-priority eligible source. At the same edge it sets that source's in-service flag.
- R7: The acknowledge bit reads 1 only in the cycle right after an acknowledge write, and 0 after that.
- R8: A source whose mode bit (address 4) is 1 (single-event) has its pending flag cleared by the acknowledge that selects it. A source whose mode bit is 0 (multiple-event) keeps its pending flag.
- R9: An acknowledge while irq_o is low loads vector number 0 and leaves the pending and in-service flags unchanged.
- R10: rd_data_o shows the register chosen by rd_addr_i one cycle later. The map is: 0 enable (1 = enabled), 1 pending, 2 in-service, 3 vector, 4 mode. Other addresses read 0.
- R11: A disabled source never raises irq_o and is never selected by an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_evt_i | input | 32 | Per-source event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Directed cases build nesting scenarios. In-service flags are set through acknowledges. Lower, equal and higher sources are then raised to show the strictly-greater gate, and in-service flags are released to show that requests are judged again. Single-event and multiple-event acknowledges for the same source tell the pending-clear rule apart from the keep rule. An acknowledge with nothing eligible is separated from one that selects a real source. A seeded random phase mixes sparse event bursts, enable, mode and clear writes, and acknowledges. After every cycle it compares the request line and random register reads with a bench model, which catches wrong ordering among several simultaneously pending sources.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int VN_W   = 5;
  localparam int VREG_W = 16;

  localparam logic [ADDR_W-1:0] RA_ENAB = 3'd0;
  localparam logic [ADDR_W-1:0] RA_PEND = 3'd1;
  localparam logic [ADDR_W-1:0] RA_INSV = 3'd2;
  localparam logic [ADDR_W-1:0] RA_VECT = 3'd3;
  localparam logic [ADDR_W-1:0] RA_MODE = 3'd4;

  localparam logic [VN_W-1:0] VN_ERROR = '0;

  // Vector register image: number in the top five bits, ack flag in bit 0.
  function automatic logic [VREG_W-1:0] pack_vector(input logic [VN_W-1:0] vn,
                                                    input logic ack);
    pack_vector = {vn, {(VREG_W-VN_W-1){1'b0}}, ack};
  endfunction

  // A request beats the in-service level only when strictly higher.
  function automatic logic outranks(input logic req_any, input logic [VN_W-1:0] req_idx,
                                    input logic isr_any, input logic [VN_W-1:0] isr_idx);
    outranks = req_any && (!isr_any || (req_idx > isr_idx));
  endfunction
endpackage

// File: rtl/nest_irq_prio.sv
module nest_irq_prio #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // Highest set index wins: the ascending scan lets the last hit overwrite.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nest_irq_srcbank.sv
module nest_irq_srcbank #(
  parameter int          N           = 32,
  parameter int          IDX_W       = 5,
  parameter logic [N-1:0] SRC_PRESENT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     evt_i,
  input  logic [N-1:0]     wr_data_i,
  input  logic             enab_we_i,
  input  logic             pend_we_i,
  input  logic             insv_we_i,
  input  logic             mode_we_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] take_idx_i,
  output logic [N-1:0]     enab_q,
  output logic [N-1:0]     pend_q,
  output logic [N-1:0]     insv_q,
  output logic [N-1:0]     mode_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (SRC_PRESENT[i]) begin : g_src
      logic en_r, pd_r, is_r, md_r;
      logic hit;
      assign hit = take_i && (take_idx_i == IDX_W'(i));

      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          en_r <= 1'b0;
          pd_r <= 1'b0;
          is_r <= 1'b0;
          md_r <= 1'b0;
        end else begin
          if (enab_we_i) en_r <= wr_data_i[i];
          if (mode_we_i) md_r <= wr_data_i[i];
          if (evt_i[i])
            pd_r <= 1'b1;
          else if ((pend_we_i && wr_data_i[i]) || (hit && md_r))
            pd_r <= 1'b0;
          if (hit)
            is_r <= 1'b1;
          else if (insv_we_i && wr_data_i[i])
            is_r <= 1'b0;
        end
      end

      assign enab_q[i] = en_r;
      assign pend_q[i] = pd_r;
      assign insv_q[i] = is_r;
      assign mode_q[i] = md_r;

      // R1: an event always leaves the pending flag set
      a_r1_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> pend_q[i]);
    end else begin : g_none
      assign enab_q[i] = 1'b0;
      assign pend_q[i] = 1'b0;
      assign insv_q[i] = 1'b0;
      assign mode_q[i] = 1'b0;
    end
  end

  // R4: absent positions stay zero in every register
  a_r4_absent_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((enab_q | pend_q | insv_q | mode_q) & ~SRC_PRESENT) == '0);

  // R6: the selected source is in service after the acknowledge edge
  a_r6_insv_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> insv_q[$past(take_idx_i)]);

  // R8: single-event source loses its pending flag on acknowledge
  a_r8_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && mode_q[take_idx_i] && !evt_i[take_idx_i]) |=> !pend_q[$past(take_idx_i)]);

  // R8: multiple-event source keeps its pending flag
  a_r8_multi_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !mode_q[take_idx_i]) |=> pend_q[$past(take_idx_i)]);
endmodule

// File: rtl/nest_irq_vecreg.sv
module nest_irq_vecreg
  import nest_irq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             grant_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  output logic             take_o,
  output logic [VN_W-1:0]  vn_q,
  output logic             ack_q
);
  assign take_o = ack_i && grant_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vn_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= ack_i;
      if (ack_i) vn_q <= grant_i ? VN_W'(grant_idx_i) : VN_ERROR;
    end
  end

  // R7: acknowledge flag only follows an acknowledge write
  a_r7_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(ack_i));

  // R9: empty acknowledge yields the error code
  a_r9_error_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !grant_i) |=> (vn_q == VN_ERROR));

  // R6: vector number holds between acknowledges
  a_r6_vn_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vn_q));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int                 N_SRC       = 32,
  parameter logic [N_SRC-1:0]   SRC_PRESENT = 32'hFFFF_FFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [N_SRC-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] enab_q, pend_q, insv_q, mode_q, live;
  logic             req_any, isr_any, grant, ack, take;
  logic [IDX_W-1:0] req_idx, isr_idx;
  logic [VN_W-1:0]  vn_q;
  logic             ack_q;

  assign ack = wr_en_i && (wr_addr_i == RA_VECT) && wr_data_i[0];
  assign live = pend_q & enab_q;

  nest_irq_srcbank #(.N(N_SRC), .IDX_W(IDX_W), .SRC_PRESENT(SRC_PRESENT)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (src_evt_i),
    .wr_data_i  (wr_data_i),
    .enab_we_i  (wr_en_i && wr_addr_i == RA_ENAB),
    .pend_we_i  (wr_en_i && wr_addr_i == RA_PEND),
    .insv_we_i  (wr_en_i && wr_addr_i == RA_INSV),
    .mode_we_i  (wr_en_i && wr_addr_i == RA_MODE),
    .take_i     (take),
    .take_idx_i (req_idx),
    .enab_q     (enab_q),
    .pend_q     (pend_q),
    .insv_q     (insv_q),
    .mode_q     (mode_q)
  );

  nest_irq_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_req_prio (
    .vec_i (live), .any_o (req_any), .idx_o (req_idx)
  );

  nest_irq_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_isr_prio (
    .vec_i (insv_q), .any_o (isr_any), .idx_o (isr_idx)
  );

  assign grant = outranks(req_any, VN_W'(req_idx), isr_any, VN_W'(isr_idx));
  assign irq_o = grant;

  nest_irq_vecreg #(.IDX_W(IDX_W)) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack),
    .grant_i     (grant),
    .grant_idx_i (req_idx),
    .take_o      (take),
    .vn_q        (vn_q),
    .ack_q       (ack_q)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
    end else begin
      unique case (rd_addr_i)
        RA_ENAB: rd_data_o <= enab_q;
        RA_PEND: rd_data_o <= pend_q;
        RA_INSV: rd_data_o <= insv_q;
        RA_VECT: rd_data_o <= N_SRC'(pack_vector(vn_q, ack_q));
        RA_MODE: rd_data_o <= mode_q;
        default: rd_data_o <= '0;
      endcase
    end
  end

  // R11: nothing enabled and pending means no request
  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live == '0) |-> !irq_o);

  // R2: with nothing in service any live source requests
  a_r2_free_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((insv_q == '0) && (live != '0)) |-> irq_o);

  // R2: the highest in-service source itself never re-requests alone
  a_r2_no_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((live & ~insv_q) == '0 && $countones(live) <= 1 && (live & insv_q) != '0
     && $onehot0(insv_q)) |-> !irq_o);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam logic [31:0] PRES = 32'hFFFF_FFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_en = '0, m_pd = '0, m_is = '0, m_md = '0;
  logic [4:0]  m_vn = '0;
  logic        m_ack = 1'b0;

  always #5 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_evt_i(src_evt_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // Winner search scanning downward from the top index.
  function automatic bit find_win(input logic [31:0] pd, en, is, output int win);
    int top_is = -1;
    win = -1;
    for (int i = 31; i >= 0; i--) if (is[i] && top_is < 0) top_is = i;
    for (int i = 31; i >= 0; i--) if (pd[i] && en[i] && win < 0) win = i;
    return (win >= 0) && (win > top_is);
  endfunction

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd0: return m_en;
      3'd1: return m_pd;
      3'd2: return m_is;
      3'd3: return {16'h0, m_vn, 10'h0, m_ack};
      3'd4: return m_md;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] evt, input logic we, input logic [2:0] a,
                      input logic [31:0] d);
    bit ok;
    int w;
    logic [31:0] bitm;
    @(negedge clk);
    src_evt_i = evt; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    @(posedge clk);
    #1;
    src_evt_i = '0; wr_en_i = 1'b0;
    ok = find_win(m_pd, m_en, m_is, w);
    m_ack = we && a == 3'd3 && d[0];
    if (m_ack) begin
      if (ok) begin
        bitm = 32'h1 << w;
        m_vn = 5'(w);
        m_is = m_is | bitm;
        if (m_md[w]) m_pd = m_pd & ~bitm;
      end else m_vn = 5'd0;
    end
    if (we) case (a)
      3'd0: m_en = d & PRES;
      3'd1: m_pd = m_pd & ~d;
      3'd2: m_is = m_is & ~d;
      3'd4: m_md = d & PRES;
      default: ;
    endcase
    m_pd = m_pd | (evt & PRES);
  endtask

  task automatic chk_irq(input string tag);
    int w;
    chk(tag, {31'h0, irq_o}, {31'h0, find_win(m_pd, m_en, m_is, w)});
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_addr_i = a;
    e = exp_reg(a);
    @(posedge clk);
    #1;
    m_ack = 1'b0;
    chk(tag, rd_data_o, e);
  endtask

  task automatic ack(); step('0, 1'b1, 3'd3, 32'h1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R5 reset state
    chk_irq("R2 reset irq");
    for (int a = 0; a < 5; a++) rd(3'(a), "R5 R10 reset read");

    // R4 absent source 0 and R1 pending set
    step(32'h0000_0001, 1'b1, 3'd0, 32'hFFFF_FFFF);
    rd(3'd1, "R4 absent pending");
    rd(3'd0, "R4 absent enable");
    // R11 masked source stays quiet
    step('0, 1'b1, 3'd0, 32'h0000_0000);
    step(32'h0010_0000, 1'b0, 3'd0, 0);
    chk_irq("R11 masked no irq");
    ack();
    rd(3'd3, "R9 empty ack error code");
    rd(3'd2, "R9 insv unchanged");
    rd(3'd1, "R9 pending unchanged");
    // R2 nesting: enable all, ack source 20 (multi-event)
    step('0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    chk_irq("R2 single live irq");
    ack();
    rd(3'd3, "R6 R7 vector 20 with ack bit");
    rd(3'd3, "R7 ack bit cleared");
    rd(3'd1, "R8 multi-event keeps pending");
    rd(3'd2, "R6 insv set");
    step(32'h0000_0400, 1'b0, 3'd0, 0);
    chk_irq("R2 lower source blocked");
    step(32'h0000_0000, 1'b1, 3'd1, 32'h0010_0000);
    chk_irq("R2 equal-or-lower blocked");
    step(32'h0200_0000, 1'b1, 3'd4, 32'h0200_0000);
    chk_irq("R2 higher source preempts");
    ack();
    rd(3'd3, "R6 vector 25");
    rd(3'd1, "R8 single-event cleared");
    step('0, 1'b1, 3'd2, 32'h0200_0000);
    chk_irq("R3 after release still blocked by 20");
    step('0, 1'b1, 3'd2, 32'h0010_0000);
    chk_irq("R3 release exposes source 10");
    // R1 event wins over software clear
    step(32'h0000_0400, 1'b1, 3'd1, 32'h0000_0400);
    rd(3'd1, "R1 event beats clear");
    // R5 reserved writes ignored
    step('0, 1'b1, 3'd3, 32'h0000_FFFE);
    rd(3'd3, "R5 reserved write no effect");
    rd(3'd7, "R10 unmapped address");

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] evt, d;
      int op;
      evt = $urandom & $urandom & $urandom & $urandom;
      d = $urandom;
      op = $urandom % 8;
      case (op)
        0: step(evt, 1'b1, 3'd0, d | $urandom);
        1: step(evt, 1'b1, 3'd1, d & $urandom);
        2: step(evt, 1'b1, 3'd2, d & $urandom & $urandom);
        3: step(evt, 1'b1, 3'd4, d);
        4, 5: step(evt, 1'b1, 3'd3, 32'h1);
        default: step(evt, 1'b0, 3'd0, 0);
      endcase
      chk_irq("R2 random irq");
      rd(3'($urandom % 5), "R10 random read");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule